// File: doc/BRIEF.md
# SD Card Command Frame Transmitter

This block turns one host command for an MMC/SD card into the 48-bit frame that travels on the single-wire command line. A requester presents a command index, a 32-bit argument and a flag that marks the index as an application-specific command, and raises `start_i` while `ready_o` is high. The block captures the request and builds the frame header. It then shifts the frame out one bit per strobe of the card-clock enable, starting with the most significant bit. The 7-bit checksum is worked out while the header bits leave, so the frame is never held in full.

When it accepts a request, the block also decodes how the card will answer. It works out the response format code, whether a data phase follows, whether that data phase writes to the card, and whether the card signals busy afterwards. Application-flagged indices use their own decode table. These attributes are registered at acceptance and held as sideband outputs for a response receiver until the next command is accepted.

Top module: `sd_cmd_tx`

## Requirements
- R1: A frame is 48 bits sent most significant first: a 0 start bit, a 1 direction bit, the 6-bit index (MSB first), the 32-bit argument (MSB first), 7 check bits, then a 1 end bit.
- R2: The check bits are the CRC over the first 40 frame bits with polynomial x^7+x^3+1 and a zero start value; for example, index 0 with argument 0 gives 0x4A, and index 8 with argument 0x1AA gives 0x43.
- R3: `cmd_o` changes only on a clock edge where `clk_en_i` is high, and each such edge during a frame drives exactly one new bit.
- R4: `cmd_o` is 1 whenever no frame is in flight. `ready_o` is low from the edge that accepts a request until the edge that drives the end bit, when it returns high. A `start_i` pulse while `ready_o` is low is ignored.
- R5: Without the application flag, `resp_type_o` is 0 for indices 0, 4 and 15; 3 for index 1; 2 for indices 2, 9 and 10; 6 for index 3; 4 for index 5; 7 for index 8; 5 for index 52; and 1 for any other index.
- R6: With the application flag set, `resp_type_o` is 3 for index 41 and 1 for every other index.
- R7: Without the application flag, `has_data_o` is 1 for indices 11, 17, 18, 20, 24, 25, 26, 27 and 42, and `is_write_o` is 1 for indices 20, 24, 25, 26, 27 and 42; both are 0 otherwise.
- R8: With the application flag set, `has_data_o` is 1 only for indices 13, 22 and 51, and `is_write_o` is always 0.
- R9: `busy_exp_o` is 1 only for indices 7 and 12 without the application flag.
- R10: The sideband outputs take their new values on the accepting edge and hold them until the next accepted request.
- R11: Out of reset, `cmd_o` and `ready_o` are 1 and all sideband outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Card-clock enable strobe; one frame bit per high cycle |
| start_i | input | 1 | Request strobe, taken when `ready_o` is high |
| cmd_index_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| app_cmd_i | input | 1 | Marks the index as an application-specific command |
| ready_o | output | 1 | High when a new request can be accepted |
| cmd_o | output | 1 | Serial command line, idles high |
| resp_type_o | output | 3 | Expected response format code |
| has_data_o | output | 1 | A data phase follows the command |
| is_write_o | output | 1 | The data phase writes to the card |
| busy_exp_o | output | 1 | The card is expected to signal busy |

## Verification
The bench builds the block with its default widths: a 6-bit index, a 32-bit argument and a 7-bit check field. That covers the full 48-bit frame and every decode entry the tables name. Frames are checked under three strobe patterns: an enable on every cycle, an enable on every third cycle, and an irregular pattern. The irregular pattern exercises held bits between strobes and the end-bit/ready handover at uneven spacing. Index sweeps with and without the application flag reach every listed decode value as well as default entries such as index 63.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef struct packed {
    logic [2:0] resp;
    logic       data;
    logic       write;
    logic       busy;
  } cmd_class_t;

  localparam cmd_class_t CLASS_RESET = '{resp: 3'd0, data: 1'b0, write: 1'b0, busy: 1'b0};

  typedef enum logic [1:0] {
    PH_HDR,
    PH_CRC,
    PH_END
  } tx_phase_e;

endpackage

// File: rtl/sd_cmd_classifier.sv
module sd_cmd_classifier
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             app_i,
  output cmd_class_t       cls_o
);

  always_comb begin
    cls_o = '{resp: 3'd1, data: 1'b0, write: 1'b0, busy: 1'b0};
    if (app_i) begin
      if (idx_i == IDX_W'(41)) cls_o.resp = 3'd3;
      case (idx_i)
        IDX_W'(13), IDX_W'(22), IDX_W'(51): cls_o.data = 1'b1;
        default: ;
      endcase
    end else begin
      case (idx_i)
        IDX_W'(0), IDX_W'(4), IDX_W'(15): cls_o.resp = 3'd0;
        IDX_W'(1):                        cls_o.resp = 3'd3;
        IDX_W'(2), IDX_W'(9), IDX_W'(10): cls_o.resp = 3'd2;
        IDX_W'(3):                        cls_o.resp = 3'd6;
        IDX_W'(5):                        cls_o.resp = 3'd4;
        IDX_W'(8):                        cls_o.resp = 3'd7;
        IDX_W'(52):                       cls_o.resp = 3'd5;
        default: ;
      endcase
      case (idx_i)
        IDX_W'(11), IDX_W'(17), IDX_W'(18): cls_o.data = 1'b1;
        IDX_W'(20), IDX_W'(24), IDX_W'(25), IDX_W'(26), IDX_W'(27), IDX_W'(42): begin
          cls_o.data  = 1'b1;
          cls_o.write = 1'b1;
        end
        default: ;
      endcase
      case (idx_i)
        IDX_W'(7), IDX_W'(12): cls_o.busy = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sd_crc_serial.sv
module sd_crc_serial #(
  parameter int             CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic feed_i,
  input  logic drain_i,
  input  logic din_i,
  output logic msb_o
);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  assign fb    = din_i ^ crc_q[CRC_W-1];
  assign msb_o = crc_q[CRC_W-1];

  always_comb begin
    crc_d = crc_q;
    if (clr_i) begin
      crc_d = '0;
    end else if (feed_i) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (drain_i) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int CRC_W = 7,
  parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_i,
  input  logic             start_i,
  input  logic [IDX_W-1:0] cmd_index_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic             app_cmd_i,
  output logic             ready_o,
  output logic             cmd_o,
  output logic [2:0]       resp_type_o,
  output logic             has_data_o,
  output logic             is_write_o,
  output logic             busy_exp_o
);

  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(HDR_W + CRC_W - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HDR_W-1:0] hdr_q, hdr_d;
  logic             cmd_q, cmd_d;
  cmd_class_t       cls_q, cls_d, cls_dec;
  tx_phase_e        phase;
  logic             accept, step, crc_msb;

  sd_cmd_classifier #(.IDX_W(IDX_W)) u_class (
    .idx_i (cmd_index_i),
    .app_i (app_cmd_i),
    .cls_o (cls_dec)
  );

  assign accept = start_i && !busy_q;
  assign step   = busy_q && clk_en_i;

  always_comb begin
    if (cnt_q <= HDR_LAST)      phase = PH_HDR;
    else if (cnt_q <= CRC_LAST) phase = PH_CRC;
    else                        phase = PH_END;
  end

  sd_crc_serial #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .feed_i  (step && (phase == PH_HDR)),
    .drain_i (step && (phase == PH_CRC)),
    .din_i   (hdr_q[HDR_W-1]),
    .msb_o   (crc_msb)
  );

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    hdr_d  = hdr_q;
    cmd_d  = cmd_q;
    cls_d  = cls_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      hdr_d  = {1'b0, 1'b1, cmd_index_i, cmd_arg_i};
      cls_d  = cls_dec;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      unique case (phase)
        PH_HDR: begin
          cmd_d = hdr_q[HDR_W-1];
          hdr_d = {hdr_q[HDR_W-2:0], 1'b0};
        end
        PH_CRC: cmd_d = crc_msb;
        default: begin
          cmd_d  = 1'b1;
          busy_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      cmd_q  <= 1'b1;
      cls_q  <= CLASS_RESET;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      cmd_q  <= cmd_d;
      cls_q  <= cls_d;
    end
  end

  assign ready_o     = !busy_q;
  assign cmd_o       = cmd_q;
  assign resp_type_o = cls_q.resp;
  assign has_data_o  = cls_q.data;
  assign is_write_o  = cls_q.write;
  assign busy_exp_o  = cls_q.busy;

endmodule

// File: rtl/sd_cmd_tx_chk.sv
module sd_cmd_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en_i,
  input logic       start_i,
  input logic       ready_o,
  input logic       cmd_o,
  input logic [2:0] resp_type_o,
  input logic       has_data_o,
  input logic       is_write_o,
  input logic       busy_exp_o
);

  // R4
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> cmd_o);

  // R3
  line_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> $stable(cmd_o));

  // R4
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> !ready_o);

  // R4
  ready_returns_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !clk_en_i) |=> !ready_o);

  // R10
  sideband_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && ready_o) |=> ($stable(resp_type_o) && $stable(has_data_o) &&
                               $stable(is_write_o) && $stable(busy_exp_o)));

  // R7
  write_implies_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_write_o |-> has_data_o);

  // R9
  busy_only_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_exp_o |-> !has_data_o);

endmodule

bind sd_cmd_tx sd_cmd_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en_i    (clk_en_i),
  .start_i     (start_i),
  .ready_o     (ready_o),
  .cmd_o       (cmd_o),
  .resp_type_o (resp_type_o),
  .has_data_o  (has_data_o),
  .is_write_o  (is_write_o),
  .busy_exp_o  (busy_exp_o)
);

// File: tb/sd_cmd_tx_test.sv
module sd_cmd_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_i = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  cmd_index_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic        app_cmd_i = 1'b0;
  logic        ready_o, cmd_o, has_data_o, is_write_o, busy_exp_o;
  logic [2:0]  resp_type_o;

  int checks = 0;
  int errors = 0;
  int en_mode = 0;
  int cycle = 0;
  logic [7:0] lfsr = 8'hA5;

  // queue item: {app, resp[2:0], data, write, busy, frame[47:0]}
  logic [54:0] sb_q[$];

  sd_cmd_tx uut (
    .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en_i), .start_i(start_i),
    .cmd_index_i(cmd_index_i), .cmd_arg_i(cmd_arg_i), .app_cmd_i(app_cmd_i),
    .ready_o(ready_o), .cmd_o(cmd_o), .resp_type_o(resp_type_o),
    .has_data_o(has_data_o), .is_write_o(is_write_o), .busy_exp_o(busy_exp_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // {resp, data, write, busy} from the requirement tables
  function automatic logic [5:0] ref_class(input logic [5:0] idx, input logic app);
    logic [2:0] r = 3'd1;
    logic d = 1'b0, w = 1'b0, b = 1'b0;
    if (app) begin
      if (idx == 41) r = 3'd3;
      if (idx == 13 || idx == 22 || idx == 51) d = 1'b1;
    end else begin
      if (idx == 0 || idx == 4 || idx == 15) r = 3'd0;
      else if (idx == 1) r = 3'd3;
      else if (idx == 2 || idx == 9 || idx == 10) r = 3'd2;
      else if (idx == 3) r = 3'd6;
      else if (idx == 5) r = 3'd4;
      else if (idx == 8) r = 3'd7;
      else if (idx == 52) r = 3'd5;
      if (idx == 11 || idx == 17 || idx == 18) d = 1'b1;
      if (idx == 20 || (idx >= 24 && idx <= 27) || idx == 42) begin d = 1'b1; w = 1'b1; end
      if (idx == 7 || idx == 12) b = 1'b1;
    end
    return {r, d, w, b};
  endfunction

  // strobe generator
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (en_mode)
      0: clk_en_i <= 1'b1;
      1: clk_en_i <= (cycle % 3 == 0);
      default: clk_en_i <= lfsr[0] | lfsr[3];
    endcase
  end

  // monitor
  logic        en_at_edge = 1'b0;
  logic        last_cmd = 1'b1;
  logic        collecting = 1'b0;
  int          nbits = 0;
  logic [47:0] got;

  always @(posedge clk) begin
    en_at_edge = clk_en_i;
    cycle++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!en_at_edge) begin
        chk("R3 line held without strobe", cmd_o, last_cmd);
      end else if (collecting || cmd_o == 1'b0) begin
        collecting = 1'b1;
        got = {got[46:0], cmd_o};
        nbits++;
        if (nbits == 48) begin
          logic [54:0] e;
          collecting = 1'b0;
          nbits = 0;
          chk("R4 ready back after end bit", ready_o, 1'b1);
          if (sb_q.size() == 0) begin
            chk("R1 unexpected frame", 1'b1, 1'b0);
          end else begin
            e = sb_q.pop_front();
            chk("R1 frame bits", got, e[47:0]);
            chk("R2 check bits", got[7:1], ref_crc(e[47:8]));
            chk(e[54] ? "R6 response code" : "R5 response code", resp_type_o, e[53:51]);
            chk(e[54] ? "R8 data flag" : "R7 data flag", has_data_o, e[50]);
            chk(e[54] ? "R8 write flag" : "R7 write flag", is_write_o, e[49]);
            chk("R9 busy flag", busy_exp_o, e[48]);
          end
        end
      end
      last_cmd = cmd_o;
    end
  end

  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic app,
                      input bit poke);
    logic [39:0] hdr;
    logic [5:0]  cls;
    while (!ready_o) @(negedge clk);
    hdr = {2'b01, idx, arg};
    cls = ref_class(idx, app);
    sb_q.push_back({app, cls, hdr, ref_crc(hdr), 1'b1});
    cmd_index_i = idx; cmd_arg_i = arg; app_cmd_i = app; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R4 ready low after accept", ready_o, 1'b0);
    chk("R10 sideband at accept", {resp_type_o, has_data_o, is_write_o, busy_exp_o}, cls);
    if (poke) begin
      repeat (5) @(negedge clk);
      // R4: start while busy must be ignored
      cmd_index_i = 6'd41; app_cmd_i = 1'b1; cmd_arg_i = 32'hFFFF_FFFF; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R10 sideband held during frame", {resp_type_o, has_data_o, is_write_o, busy_exp_o}, cls);
    end
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    #(CLK_PERIOD * 3 + 1);
    chk("R11 reset line", cmd_o, 1'b1);
    chk("R11 reset ready", ready_o, 1'b1);
    chk("R11 reset sideband", {resp_type_o, has_data_o, is_write_o, busy_exp_o}, 6'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 idle line", cmd_o, 1'b1);

    // known check values (R2)
    chk("R2 known crc idx0", ref_crc({2'b01, 6'd0, 32'd0}), 7'h4A);
    chk("R2 known crc idx8", ref_crc({2'b01, 6'd8, 32'h1AA}), 7'h43);
    send(6'd0, 32'd0, 1'b0, 1'b0);
    send(6'd8, 32'h0000_01AA, 1'b0, 1'b0);

    for (int m = 0; m < 3; m++) begin
      en_mode = m;
      send(6'd17, 32'hDEAD_BEEF, 1'b0, 1'b1);
      send(6'd52, 32'h8800_0C08, 1'b0, 1'b0);
      send(6'd41, 32'h40FF_8000, 1'b1, 1'b0);
      send(6'd63, 32'h5555_AAAA, 1'b0, 1'b0);
    end

    en_mode = 0;
    foreach (sb_q[i]) begin end
    for (int i = 0; i < 64; i++) begin
      send(6'(i), 32'h1234_5678 ^ (i * 32'h0101_0101), 1'b0, 1'b0);
    end
    en_mode = 2;
    for (int i = 0; i < 64; i += 3) begin
      send(6'(i), ~(i * 32'h0F0F_0F0F), 1'b1, 1'b0);
    end
    send(6'd13, 32'h0, 1'b1, 1'b0);
    send(6'd22, 32'h0, 1'b1, 1'b0);
    send(6'd51, 32'h0, 1'b1, 1'b0);
    send(6'd24, 32'h0, 1'b1, 1'b0);
    send(6'd12, 32'h0, 1'b1, 1'b0);
    send(6'd7, 32'h0001_0000, 1'b0, 1'b1);

    repeat (10) @(negedge clk);
    chk("R1 all frames seen", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule